// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs one master transfer on an I2C bus, one bus bit slot per `bit_tick` pulse. Software-style control inputs select the module enable, master operation, direction and 7-bit or 10-bit addressing. Two set-only request bits ask for a START and a STOP. Each of these request bits clears itself once the matching bus condition has been issued. The sequencer issues START, shifts out the address phase, then either sends bytes taken from `tx_data` or collects bytes into `rx_data`, and checks or gives the acknowledge after every byte.

When the programmed byte count has been moved, the block raises a completion event. If a STOP is pending, it ends the transfer on the same tick. If none is pending, it keeps the bus so that the next start request produces a repeated START. A missing acknowledge and a lost arbitration each raise their own one-cycle event. SCL timing, data buffering and slave operation belong to surrounding logic.

Top module: `i2cseq_top`

## Requirements
- R1: After reset, `sda_o` is 1 and `busy`, `start_pend`, `stop_pend` and every event output are 0.
- R2: A `start_set` pulse sets `start_pend`. On the next `bit_tick` with `cfg_en` and `cfg_master` both high, the block pulses `start_cond`, sets `busy` and clears `start_pend`. While `cfg_master` is low, the request stays pending and no START is issued.
- R3: In 7-bit mode the address byte is `{slave_addr[6:0], R/W}`, with R/W = 1 for receive (`cfg_tx` = 0). It is driven MSB first on `sda_o`, one bit per tick, and `slave_addr[9:7]` are ignored.
- R4: In 10-bit mode the first address byte is `{5'b11110, slave_addr[9:8], R/W}`. After it is acknowledged, `slave_addr[7:0]` is sent as a second byte.
- R5: After the eighth bit of any transmitted byte, `sda_o` is released to 1 for the acknowledge slot. A 0 sampled on `sda_in` at the next tick is an ACK.
- R6: A 1 sampled in an acknowledge slot pulses `evt_nack`, and no STOP is issued while `stop_pend` is low. STOP (`stop_cond`) is issued on the first tick that finds `stop_pend` set.
- R7: When the block drives 1 in an address or data bit and samples 0 on `sda_in`, it pulses `evt_al`, clears `busy`, `start_pend` and `stop_pend`, and releases `sda_o` to 1.
- R8: In transmit mode, each data byte is loaded from `tx_data` with a one-cycle `tx_take` pulse and sent MSB first. Exactly `byte_count` bytes are sent.
- R9: In receive mode, bits are shifted in MSB first. After the eighth bit, `rx_valid` pulses with the byte on `rx_data`. The block then drives 0 (ACK) in the acknowledge slot of every byte except the last, where it drives 1.
- R10: The tick that ends the final acknowledge slot pulses `evt_ardy`. If `stop_pend` is set, the same tick pulses `stop_cond` and clears `busy` and `stop_pend`.
- R11: With no stop pending at completion, `busy` stays 1 and no STOP is issued. A later start request issues a repeated START.
- R12: A stop request made while a start is still pending is kept. Issuing the START clears only `start_pend`.
- R13: While `cfg_en` is low, both request bits are cleared, `busy` is cleared and the sequencer returns to idle.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | Advances the sequencer by one bus bit slot |
| cfg_en | input | 1 | Module enable |
| cfg_master | input | 1 | Master operation select |
| cfg_tx | input | 1 | 1 transmit, 0 receive |
| cfg_ten_bit | input | 1 | 10-bit addressing |
| start_set | input | 1 | Sets the start request bit |
| stop_set | input | 1 | Sets the stop request bit |
| slave_addr | input | 10 | Target address |
| byte_count | input | CNT_W | Number of data bytes |
| tx_data | input | 8 | Next byte to transmit |
| sda_in | input | 1 | Sampled bus data line |
| sda_o | output | 1 | Data level driven for the current slot (1 = released) |
| start_cond | output | 1 | Pulse: START issued |
| stop_cond | output | 1 | Pulse: STOP issued |
| busy | output | 1 | Bus owned from START to STOP |
| start_pend | output | 1 | Start request bit |
| stop_pend | output | 1 | Stop request bit |
| evt_ardy | output | 1 | Pulse: programmed access finished |
| evt_nack | output | 1 | Pulse: acknowledge missing |
| evt_al | output | 1 | Pulse: arbitration lost |
| tx_take | output | 1 | Pulse: `tx_data` consumed |
| rx_valid | output | 1 | Pulse: `rx_data` holds a new byte |
| rx_data | output | 8 | Last received byte |

## Verification
The bench builds the block with the default `CNT_W` of 8, so byte counts of 0, 1 and 2 cover zero-length probes, single bytes and the last-byte NACK in receive. Every bit slot is driven from the bench. This makes arbitration loss, a missing acknowledge and a repeated START reachable at exactly chosen bits.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEND,
        PH_ACKCHK,
        PH_RXD,
        PH_ACKDRV,
        PH_HOLD,
        PH_WAITSTOP
    } phase_e;

    localparam logic [4:0] TEN_BIT_HDR = 5'b11110;

    localparam logic [1:0] STG_DATA  = 2'd0;
    localparam logic [1:0] STG_ADDR1 = 2'd1;
    localparam logic [1:0] STG_ADDR2 = 2'd2;

endpackage

// File: rtl/i2cseq_addr_fmt.sv
module i2cseq_addr_fmt
    import i2cseq_pkg::*;
(
    input  logic       ten_bit,
    input  logic       rd,
    input  logic [9:0] addr,
    output logic [7:0] first_byte,
    output logic [7:0] second_byte
);

    always_comb begin
        if (ten_bit) begin
            first_byte = {TEN_BIT_HDR, addr[9:8], rd};
        end else begin
            first_byte = {addr[6:0], rd};
        end
        second_byte = addr[7:0];
    end

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             cfg_en,
    input  logic             cfg_master,
    input  logic             cfg_tx,
    input  logic             cfg_ten_bit,
    input  logic             start_set,
    input  logic             stop_set,
    input  logic [9:0]       slave_addr,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       tx_data,
    input  logic             sda_in,
    output logic             sda_o,
    output logic             start_cond,
    output logic             stop_cond,
    output logic             busy,
    output logic             start_pend,
    output logic             stop_pend,
    output logic             evt_ardy,
    output logic             evt_nack,
    output logic             evt_al,
    output logic             tx_take,
    output logic             rx_valid,
    output logic [7:0]       rx_data
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        logic [1:0]       stage;
        logic [7:0]       sh;
        logic [2:0]       idx;
        logic [CNT_W-1:0] remain;
        logic             busy;
        logic             spend;
        logic             ppend;
        logic             sda;
        logic             scond;
        logic             pcond;
        logic             ardy;
        logic             nack;
        logic             al;
        logic             take;
        logic             rxv;
        logic [7:0]       rxd;
    } seq_t;

    seq_t q, d;

    logic [7:0]       addr_b1, addr_b2;
    logic [CNT_W-1:0] cnt_after;
    logic             do_done, do_stop;

    i2cseq_addr_fmt u_addr_fmt (
        .ten_bit    (cfg_ten_bit),
        .rd         (~cfg_tx),
        .addr       (slave_addr),
        .first_byte (addr_b1),
        .second_byte(addr_b2)
    );

    always_comb begin
        d         = q;
        d.scond   = 1'b0;
        d.pcond   = 1'b0;
        d.ardy    = 1'b0;
        d.nack    = 1'b0;
        d.al      = 1'b0;
        d.take    = 1'b0;
        d.rxv     = 1'b0;
        do_done   = 1'b0;
        do_stop   = 1'b0;
        cnt_after = (q.stage == STG_DATA) ? q.remain - CNT_ONE : q.remain;

        if (start_set) d.spend = 1'b1;
        if (stop_set)  d.ppend = 1'b1;

        if (!cfg_en) begin
            d.phase = PH_IDLE;
            d.spend = 1'b0;
            d.ppend = 1'b0;
            d.busy  = 1'b0;
            d.sda   = 1'b1;
        end else if (bit_tick) begin
            case (q.phase)
                PH_IDLE, PH_HOLD: begin
                    if (q.phase == PH_HOLD && q.ppend) begin
                        do_stop = 1'b1;
                    end else if (q.spend && cfg_master) begin
                        d.scond  = 1'b1;
                        d.spend  = 1'b0;
                        d.busy   = 1'b1;
                        d.phase  = PH_SEND;
                        d.stage  = STG_ADDR1;
                        d.sh     = addr_b1;
                        d.sda    = addr_b1[7];
                        d.idx    = 3'd7;
                        d.remain = byte_count;
                    end
                end
                PH_SEND: begin
                    if (q.sda && !sda_in) begin
                        d.al    = 1'b1;
                        d.phase = PH_IDLE;
                        d.busy  = 1'b0;
                        d.spend = 1'b0;
                        d.ppend = 1'b0;
                        d.sda   = 1'b1;
                    end else if (q.idx == 3'd0) begin
                        d.phase = PH_ACKCHK;
                        d.sda   = 1'b1;
                    end else begin
                        d.idx = q.idx - 3'd1;
                        d.sh  = {q.sh[6:0], 1'b0};
                        d.sda = q.sh[6];
                    end
                end
                PH_ACKCHK: begin
                    if (sda_in) begin
                        d.nack  = 1'b1;
                        d.phase = PH_WAITSTOP;
                        d.sda   = 1'b1;
                    end else if (q.stage == STG_ADDR1 && cfg_ten_bit) begin
                        d.stage = STG_ADDR2;
                        d.phase = PH_SEND;
                        d.sh    = addr_b2;
                        d.sda   = addr_b2[7];
                        d.idx   = 3'd7;
                    end else begin
                        d.remain = cnt_after;
                        if (cnt_after == '0) begin
                            do_done = 1'b1;
                        end else if (cfg_tx) begin
                            d.take  = 1'b1;
                            d.stage = STG_DATA;
                            d.phase = PH_SEND;
                            d.sh    = tx_data;
                            d.sda   = tx_data[7];
                            d.idx   = 3'd7;
                        end else begin
                            d.phase = PH_RXD;
                            d.sda   = 1'b1;
                            d.idx   = 3'd7;
                        end
                    end
                end
                PH_RXD: begin
                    d.sh = {q.sh[6:0], sda_in};
                    if (q.idx == 3'd0) begin
                        d.rxv   = 1'b1;
                        d.rxd   = {q.sh[6:0], sda_in};
                        d.phase = PH_ACKDRV;
                        d.sda   = (q.remain == CNT_ONE);
                    end else begin
                        d.idx = q.idx - 3'd1;
                    end
                end
                PH_ACKDRV: begin
                    d.remain = q.remain - CNT_ONE;
                    if (q.remain == CNT_ONE) begin
                        do_done = 1'b1;
                    end else begin
                        d.phase = PH_RXD;
                        d.sda   = 1'b1;
                        d.idx   = 3'd7;
                    end
                end
                PH_WAITSTOP: begin
                    if (q.ppend) do_stop = 1'b1;
                end
                default: d.phase = PH_IDLE;
            endcase

            if (do_done) begin
                d.ardy = 1'b1;
                if (q.ppend) begin
                    do_stop = 1'b1;
                end else begin
                    d.phase = PH_HOLD;
                    d.sda   = 1'b1;
                end
            end
            if (do_stop) begin
                d.pcond = 1'b1;
                d.ppend = 1'b0;
                d.busy  = 1'b0;
                d.phase = PH_IDLE;
                d.sda   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
            q.sda   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_o      = q.sda;
    assign start_cond = q.scond;
    assign stop_cond  = q.pcond;
    assign busy       = q.busy;
    assign start_pend = q.spend;
    assign stop_pend  = q.ppend;
    assign evt_ardy   = q.ardy;
    assign evt_nack   = q.nack;
    assign evt_al     = q.al;
    assign tx_take    = q.take;
    assign rx_valid   = q.rxv;
    assign rx_data    = q.rxd;

    // R2: a START always opens bus ownership
    p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_cond |-> busy && !start_pend);

    // R6: STOP only follows a pending stop request
    p_stop_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cond |-> $past(stop_pend));

    // R6: status events are mutually exclusive
    p_events_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({evt_ardy, evt_nack, evt_al}) <= 1);

    // R7: arbitration loss follows a driven 1 read back as 0
    p_al_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_al |-> $past(sda_o) && !$past(sda_in) && !busy && sda_o);

    // R10: STOP ends ownership and consumes the request
    p_stop_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cond |-> !busy && !stop_pend);

    // R13: disable wipes both request bits and ownership
    p_disable_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !start_pend && !stop_pend && !busy);

endmodule

// File: tb/i2cseq_top_bench.sv
`timescale 1ns/100ps
module i2cseq_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       cfg_en = 1'b1, cfg_master = 1'b1, cfg_tx = 1'b1, cfg_ten_bit = 1'b0;
    logic       start_set = 1'b0, stop_set = 1'b0;
    logic [9:0] slave_addr = '0;
    logic [7:0] byte_count = '0;
    logic [7:0] tx_data = '0;
    logic       sda_in = 1'b1;
    logic       sda_o, start_cond, stop_cond, busy, start_pend, stop_pend;
    logic       evt_ardy, evt_nack, evt_al, tx_take, rx_valid;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] got;

    always #2.5 clk = ~clk;

    i2cseq_top u_i2cseq_top (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_en(cfg_en),
        .cfg_master(cfg_master), .cfg_tx(cfg_tx), .cfg_ten_bit(cfg_ten_bit),
        .start_set(start_set), .stop_set(stop_set), .slave_addr(slave_addr),
        .byte_count(byte_count), .tx_data(tx_data), .sda_in(sda_in),
        .sda_o(sda_o), .start_cond(start_cond), .stop_cond(stop_cond),
        .busy(busy), .start_pend(start_pend), .stop_pend(stop_pend),
        .evt_ardy(evt_ardy), .evt_nack(evt_nack), .evt_al(evt_al),
        .tx_take(tx_take), .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // {ten_bit, tx, addr, first byte, second byte}
    localparam int NV = 4;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 1'b1, 10'h050, 8'hA0, 8'h00},
        {1'b0, 1'b0, 10'h3A3, 8'h47, 8'h00},
        {1'b1, 1'b1, 10'h2A5, 8'hF4, 8'hA5},
        {1'b1, 1'b0, 10'h1C3, 8'hF3, 8'hC3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic b);
        bit_tick = 1'b1;
        sda_in   = b;
        @(negedge clk);
        bit_tick = 1'b0;
        sda_in   = 1'b1;
    endtask

    task automatic pulse_req(input logic s, input logic p);
        start_set = s;
        stop_set  = p;
        @(negedge clk);
        start_set = 1'b0;
        stop_set  = 1'b0;
    endtask

    task automatic shift_out(output logic [7:0] b);
        b[7] = sda_o;
        for (int i = 6; i >= 0; i--) begin
            step(sda_o);
            b[i] = sda_o;
        end
        step(sda_o);
    endtask

    task automatic feed_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) step(b[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sda_o", sda_o, 1);
        check("R1 idle flags", {busy, start_pend, stop_pend, evt_ardy, evt_nack, evt_al}, 0);

        // table of address formats, zero-length transfers with STOP
        for (int v = 0; v < NV; v++) begin
            cfg_ten_bit = VEC[v][27];
            cfg_tx      = VEC[v][26];
            slave_addr  = VEC[v][25:16];
            byte_count  = 8'd0;
            pulse_req(1'b1, 1'b1);
            check("R12 both pending", {start_pend, stop_pend}, 2'b11);
            step(1'b1);
            check("R2 start issued", {start_cond, busy, start_pend}, 3'b110);
            check("R12 stop kept", stop_pend, 1);
            shift_out(got);
            check(VEC[v][27] ? "R4 first byte" : "R3 address byte", got, VEC[v][15:8]);
            check("R5 ack slot released", sda_o, 1);
            step(1'b0);
            if (VEC[v][27]) begin
                shift_out(got);
                check("R4 second byte", got, VEC[v][7:0]);
                step(1'b0);
            end
            check("R10 done and stop", {evt_ardy, stop_cond, busy, stop_pend}, 4'b1100);
        end
        cfg_ten_bit = 1'b0;

        // R6 NACK waits for a stop request
        cfg_tx = 1'b1; slave_addr = 10'h050; byte_count = 8'd1;
        pulse_req(1'b1, 1'b0);
        step(1'b1);
        shift_out(got);
        step(1'b1);
        check("R6 nack event", {evt_nack, evt_ardy, busy, stop_cond}, 4'b1010);
        step(1'b1);
        check("R6 no stop unrequested", {stop_cond, busy}, 2'b01);
        pulse_req(1'b0, 1'b1);
        step(1'b1);
        check("R6 stop after request", {stop_cond, busy}, 2'b10);

        // R7 arbitration loss on the first address bit (driven 1)
        pulse_req(1'b1, 1'b1);
        step(1'b1);
        check("R7 driving one", sda_o, 1);
        step(1'b0);
        check("R7 lost", {evt_al, busy, start_pend, stop_pend, sda_o}, 5'b10001);

        // R8 two transmitted bytes
        byte_count = 8'd2; tx_data = 8'h3C;
        pulse_req(1'b1, 1'b1);
        step(1'b1);
        shift_out(got);
        step(1'b0);
        check("R8 first take", tx_take, 1);
        tx_data = 8'hC5;
        shift_out(got);
        check("R8 first byte", got, 8'h3C);
        step(1'b0);
        check("R8 second take", tx_take, 1);
        shift_out(got);
        check("R8 second byte", got, 8'hC5);
        step(1'b0);
        check("R10 tx done", {evt_ardy, stop_cond, busy}, 3'b110);

        // R9 two received bytes
        cfg_tx = 1'b0; slave_addr = 10'h023;
        pulse_req(1'b1, 1'b1);
        step(1'b1);
        shift_out(got);
        check("R3 read address", got, 8'h47);
        step(1'b0);
        check("R9 released for data", sda_o, 1);
        feed_byte(8'h96);
        check("R9 first byte", {rx_valid, rx_data, sda_o}, {1'b1, 8'h96, 1'b0});
        step(1'b1);
        feed_byte(8'h5A);
        check("R9 last byte nack", {rx_valid, rx_data, sda_o}, {1'b1, 8'h5A, 1'b1});
        step(1'b1);
        check("R10 rx done", {evt_ardy, stop_cond, busy}, 3'b110);

        // R11 hold bus then repeated START
        cfg_tx = 1'b1; byte_count = 8'd0;
        pulse_req(1'b1, 1'b0);
        step(1'b1);
        shift_out(got);
        step(1'b0);
        check("R11 held", {evt_ardy, stop_cond, busy}, 3'b101);
        step(1'b1);
        step(1'b1);
        check("R11 still held", {stop_cond, start_cond, busy}, 3'b001);
        pulse_req(1'b1, 1'b0);
        step(1'b1);
        check("R11 repeated start", {start_cond, busy}, 2'b11);
        shift_out(got);
        pulse_req(1'b0, 1'b1);
        step(1'b0);
        check("R11 closing stop", {evt_ardy, stop_cond, busy}, 3'b110);

        // R2 slave operation keeps the request pending
        cfg_master = 1'b0;
        pulse_req(1'b1, 1'b0);
        step(1'b1);
        check("R2 no start when not master", {start_cond, start_pend, busy}, 3'b010);
        cfg_master = 1'b1;
        step(1'b1);
        check("R2 start once master", {start_cond, start_pend}, 2'b10);

        // R13 disable mid-transfer
        pulse_req(1'b0, 1'b1);
        cfg_en = 1'b0;
        @(negedge clk);
        check("R13 disabled", {busy, start_pend, stop_pend, sda_o}, 4'b0001);
        pulse_req(1'b1, 1'b0);
        check("R13 request ignored", start_pend, 0);
        cfg_en = 1'b1;
        step(1'b1);
        check("R13 stays idle", {start_cond, busy}, 2'b00);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule